// File: doc/BRIEF.md
# Frame-Synchronized Serial Word Transmitter

This block takes parallel words through a valid/ready handshake and sends each one out serially, most significant bit first, in step with an externally supplied bit clock. Each word belongs to one frame, and a frame begins with a frame-sync pulse. The block either produces that pulse itself, one bit clock wide at a programmable period, or takes it from outside. A two-bit data-delay setting decides whether the first bit comes out with the frame sync itself or one or two bit clocks later. Outside the bits of a frame the data pin is released, which shows as a low output enable.

The bit clock and frame sync are ordinary inputs that are synchronous to the system clock and much slower than it. The block finds their edges with registers in the system clock domain. Clock and frame-sync polarity are selectable. An enable-extension option holds the data pin released for the first half of the first bit. If a frame starts before a fresh word has arrived, the previous word goes out again and a sticky flag records the underflow.

Top module: `fsync_serial_tx`

## Requirements
- R1: During and directly after reset, `tx_oe` is 0, `tx_d` is 0, `in_ready` is 1, `underflow` is 0 and `fs_out` sits at its inactive level, which equals `cfg_fs_pol`.
- R2: A word of `cfg_len_m1`+1 bits (8 to 32) goes out from its bit `cfg_len_m1` down to bit 0, one bit per bit clock. Each bit changes only on a launch edge, which is the rising `sclk` edge when `cfg_clk_pol` is 0.
- R3: With `cfg_delay` = 0, the first bit is driven in the same bit period in which the frame sync becomes active.
- R4: With `cfg_delay` = 1 or 2, the first bit is driven on the first or second launch edge after the frame start.
- R5: Whenever no bit is being sent, including the bit period that follows bit 0, `tx_oe` is 0 and `tx_d` is 0.
- R6: With `cfg_ext_en` = 1, `tx_oe` stays 0 during the first half of the first bit of each frame and rises at the following sample edge. The other bits are unaffected.
- R7: With `cfg_fs_int` = 1, `fs_out` is active for exactly one bit clock every `cfg_fs_period_m1`+1 bit clocks, and it changes only on launch edges. The first pulse comes on the first launch edge after reset.
- R8: With `cfg_fs_int` = 0, `fs_in` is sampled on the sample edge, which is the falling `sclk` edge when `cfg_clk_pol` is 0. A sample at the active level that follows a sample at the inactive level starts a frame. The frame then keeps the same bit timing as in R3 and R4.
- R9: `cfg_clk_pol` = 1 swaps the launch and sample edges. `cfg_fs_pol` = 1 makes both `fs_in` and `fs_out` active low.
- R10: If a frame starts while no unsent word is held, the previously sent word is sent again and `underflow` becomes 1 and stays 1 until reset.
- R11: `in_ready` is 1 exactly when no unsent word is held. After a word is accepted it is 0 until the next frame takes that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Bit clock, synchronous to `clk` |
| fs_in | input | 1 | External frame sync |
| fs_out | output | 1 | Internally generated frame sync |
| cfg_len_m1 | input | 5 | Word length minus one (7 to 31) |
| cfg_delay | input | 2 | Data delay in bit clocks (0, 1, 2; 3 acts as 2) |
| cfg_ext_en | input | 1 | Hold the first bit released for half a bit |
| cfg_fs_int | input | 1 | 1 = generate frame sync, 0 = use `fs_in` |
| cfg_fs_period_m1 | input | 8 | Internal frame-sync period in bit clocks minus one |
| cfg_clk_pol | input | 1 | Bit clock polarity |
| cfg_fs_pol | input | 1 | Frame sync polarity |
| in_data | input | 32 | Word to send, right-aligned |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Holding register is empty |
| tx_d | output | 1 | Serial data |
| tx_oe | output | 1 | Data pin driven when 1 |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The assertions assume that `sclk` stays at each level for at least two system clocks. They also assume that the configuration inputs change only while reset is held, and that an external frame sync changes only together with a launch edge. The bench meets these limits by design. It holds each `sclk` level for four system clocks and changes the configuration only under reset. It drives `fs_in` at the same instant as the launch edge, for one bit clock per frame. The stimulus writes each word one frame ahead, except for one frame per configuration that is deliberately left without a word.

// File: rtl/fst_pkg.sv
package fst_pkg;

    localparam int unsigned FST_MAX_BITS = 32;
    localparam int unsigned FST_PER_W    = 8;

    typedef enum logic [1:0] {
        DLY_NONE = 2'd0,
        DLY_ONE  = 2'd1,
        DLY_TWO  = 2'd2,
        DLY_TWOX = 2'd3
    } fst_delay_e;

    typedef struct packed {
        logic launch;   // edge on which data and internal sync change
        logic sample;   // opposite edge, external sync capture
        logic tick;     // frame start event
        logic go0;      // frame start for zero-delay mode
    } fst_events_t;

    // number of launch edges between frame start and the first bit
    function automatic logic [1:0] lead_count(input fst_delay_e d);
        case (d)
            DLY_NONE: return 2'd0;
            DLY_ONE:  return 2'd1;
            default:  return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/fst_clk_edges.sv
module fst_clk_edges (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic clk_pol,
    output logic launch,
    output logic sample
);
    logic sclk_q;
    logic now_hi;
    logic was_hi;

    always_ff @(posedge clk) begin
        sclk_q <= sclk;
    end

    assign now_hi = sclk ^ clk_pol;
    assign was_hi = sclk_q ^ clk_pol;

    always_comb begin
        launch = !rst && now_hi && !was_hi;
        sample = !rst && !now_hi && was_hi;
    end
endmodule

// File: rtl/fst_fsync.sv
module fst_fsync #(
    parameter int unsigned PER_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             sample,
    input  logic             use_int,
    input  logic [PER_W-1:0] per_m1,
    input  logic             fs_pol,
    input  logic             fs_in,
    output logic             fs_out,
    output logic             tick,
    output logic             go0
);
    logic             fs_lvl;
    logic             fs_lvl_q;
    logic             fs_smp;
    logic             fs_gen;
    logic [PER_W-1:0] fs_cnt;
    logic             int_start;
    logic             ext_start;
    logic             ext_rise;

    assign fs_lvl = fs_in ^ fs_pol;

    always_ff @(posedge clk) begin
        fs_lvl_q <= fs_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_cnt <= '0;
            fs_gen <= 1'b0;
            fs_smp <= 1'b0;
        end else begin
            if (launch) begin
                if (fs_cnt == '0) begin
                    fs_gen <= 1'b1;
                    fs_cnt <= per_m1;
                end else begin
                    fs_gen <= 1'b0;
                    fs_cnt <= PER_W'(fs_cnt - 1'b1);
                end
            end
            if (sample) begin
                fs_smp <= fs_lvl;
            end
        end
    end

    assign int_start = launch && (fs_cnt == '0);
    assign ext_start = sample && fs_lvl && !fs_smp;
    assign ext_rise  = !rst && fs_lvl && !fs_lvl_q;

    assign tick   = use_int ? int_start : ext_start;
    assign go0    = use_int ? int_start : ext_rise;
    assign fs_out = (fs_gen && use_int) ^ fs_pol;
endmodule

// File: rtl/fst_word_buf.sv
module fst_word_buf #(
    parameter int unsigned MAX_BITS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [MAX_BITS-1:0] in_data,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                take,
    output logic [MAX_BITS-1:0] word,
    output logic                underflow
);
    logic [MAX_BITS-1:0] hold;
    logic                full;

    assign in_ready = !full;
    assign word     = hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold      <= '0;
            full      <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (take) begin
                full <= 1'b0;
                if (!full) begin
                    underflow <= 1'b1;
                end
            end
            if (in_valid && !full) begin
                hold <= in_data;
                full <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fst_shifter.sv
module fst_shifter
    import fst_pkg::*;
#(
    parameter int unsigned MAX_BITS = 32,
    localparam int unsigned LEN_W   = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  fst_events_t         ev,
    input  fst_delay_e          dly,
    input  logic                ext_en,
    input  logic [LEN_W-1:0]    len_m1,
    input  logic [MAX_BITS-1:0] word,
    output logic                take,
    output logic                tx_d,
    output logic                tx_oe
);
    localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(MAX_BITS - 1);

    logic                active;
    logic                hold_off;
    logic                pend;
    logic [1:0]          lead;
    logic [LEN_W-1:0]    idx;
    logic [MAX_BITS-1:0] sreg;
    logic                zero_dly;
    logic                go;

    assign zero_dly = (dly == DLY_NONE);
    assign go       = (zero_dly && ev.go0) || (ev.launch && pend && lead == 2'd1);
    assign take     = go;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            hold_off <= 1'b0;
            pend     <= 1'b0;
            lead     <= '0;
            idx      <= '0;
            sreg     <= '0;
        end else begin
            if (ev.tick && !zero_dly) begin
                pend <= 1'b1;
                lead <= lead_count(dly);
            end else if (ev.launch && pend) begin
                lead <= 2'(lead - 2'd1);
                if (lead == 2'd1) begin
                    pend <= 1'b0;
                end
            end

            if (ev.sample) begin
                hold_off <= 1'b0;
            end

            if (go) begin
                active   <= 1'b1;
                idx      <= len_m1;
                sreg     <= word << (TOP_IDX - len_m1);
                hold_off <= ext_en;
            end else if (ev.launch && active) begin
                if (idx == '0) begin
                    active <= 1'b0;
                end else begin
                    idx  <= LEN_W'(idx - 1'b1);
                    sreg <= sreg << 1;
                end
            end
        end
    end

    assign tx_oe = active && !hold_off;
    assign tx_d  = tx_oe && sreg[MAX_BITS-1];
endmodule

// File: rtl/fsync_serial_tx.sv
module fsync_serial_tx
    import fst_pkg::*;
#(
    parameter int unsigned MAX_BITS = FST_MAX_BITS,
    parameter int unsigned PER_W    = FST_PER_W,
    localparam int unsigned LEN_W   = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk,
    input  logic                fs_in,
    output logic                fs_out,
    input  logic [LEN_W-1:0]    cfg_len_m1,
    input  logic [1:0]          cfg_delay,
    input  logic                cfg_ext_en,
    input  logic                cfg_fs_int,
    input  logic [PER_W-1:0]    cfg_fs_period_m1,
    input  logic                cfg_clk_pol,
    input  logic                cfg_fs_pol,
    input  logic [MAX_BITS-1:0] in_data,
    input  logic                in_valid,
    output logic                in_ready,
    output logic                tx_d,
    output logic                tx_oe,
    output logic                underflow
);
    fst_events_t         ev;
    logic                take;
    logic [MAX_BITS-1:0] word;

    fst_clk_edges u_edges (
        .clk     (clk),
        .rst     (rst),
        .sclk    (sclk),
        .clk_pol (cfg_clk_pol),
        .launch  (ev.launch),
        .sample  (ev.sample)
    );

    fst_fsync #(.PER_W(PER_W)) u_fsync (
        .clk     (clk),
        .rst     (rst),
        .launch  (ev.launch),
        .sample  (ev.sample),
        .use_int (cfg_fs_int),
        .per_m1  (cfg_fs_period_m1),
        .fs_pol  (cfg_fs_pol),
        .fs_in   (fs_in),
        .fs_out  (fs_out),
        .tick    (ev.tick),
        .go0     (ev.go0)
    );

    fst_word_buf #(.MAX_BITS(MAX_BITS)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .take      (take),
        .word      (word),
        .underflow (underflow)
    );

    fst_shifter #(.MAX_BITS(MAX_BITS)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .dly    (fst_delay_e'(cfg_delay)),
        .ext_en (cfg_ext_en),
        .len_m1 (cfg_len_m1),
        .word   (word),
        .take   (take),
        .tx_d   (tx_d),
        .tx_oe  (tx_oe)
    );
endmodule

// File: rtl/fst_tx_checker.sv
module fst_tx_checker (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic cfg_clk_pol,
    input logic cfg_fs_pol,
    input logic cfg_fs_int,
    input logic fs_out,
    input logic in_valid,
    input logic in_ready,
    input logic tx_d,
    input logic tx_oe,
    input logic underflow
);
    logic sck_q;
    logic lnch;

    always_ff @(posedge clk) begin
        sck_q <= sclk;
    end

    assign lnch = (sclk ^ cfg_clk_pol) && !(sck_q ^ cfg_clk_pol);

    // R11: an accepted word blocks further writes
    a_r11_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R10: underflow flag is sticky
    a_r10_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);

    // R5: released pin carries no data
    a_r5_quiet_when_released: assert property (@(posedge clk) disable iff (rst)
        !tx_oe |-> !tx_d);

    // R2: data bits inside a frame move only after a launch edge
    a_r2_bits_move_on_launch: assert property (@(posedge clk) disable iff (rst)
        (tx_oe && $past(tx_oe) && tx_d != $past(tx_d)) |-> $past(lnch));

    // R7: generated frame sync moves only after a launch edge
    a_r7_fs_moves_on_launch: assert property (@(posedge clk) disable iff (rst)
        (cfg_fs_int && $past(cfg_fs_int) && $stable(cfg_fs_pol) && fs_out != $past(fs_out))
        |-> $past(lnch));
endmodule

bind fsync_serial_tx fst_tx_checker u_chk (.*);

// File: tb/fsync_serial_tx_test.sv
module fsync_serial_tx_test;
    localparam int HALF = 4;
    localparam int NF   = 6;
    localparam int SKIP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        fs_in = 1'b0;
    logic        fs_out;
    logic [4:0]  cfg_len_m1 = 5'd7;
    logic [1:0]  cfg_delay = 2'd0;
    logic        cfg_ext_en = 1'b0;
    logic        cfg_fs_int = 1'b1;
    logic [7:0]  cfg_fs_period_m1 = 8'd7;
    logic        cfg_clk_pol = 1'b0;
    logic        cfg_fs_pol = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        tx_d;
    logic        tx_oe;
    logic        underflow;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [31:0] words [NF];

    always #4 clk = ~clk;

    fsync_serial_tx uut (.*);

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_for(input int f);
        int g = f;
        if (g >= NF) g = NF - 1;
        if (g == SKIP) g = SKIP - 1;
        return words[g];
    endfunction

    task automatic run_config(input int len, input int d, input int per, input bit int_mode,
                              input bit cpol, input bit fpol, input bit xen, input int k);
        string ptag;
        ptag = (cpol || fpol) ? " R9" : "";
        for (int f = 0; f < NF; f++) words[f] = 32'h9E3779B9 * (k * 8 + f + 1) + 32'h1357;

        @(negedge clk);
        rst = 1'b1;
        cfg_len_m1 = 5'(len - 1);
        cfg_delay = 2'(d);
        cfg_fs_period_m1 = 8'(per - 1);
        cfg_fs_int = int_mode;
        cfg_clk_pol = cpol;
        cfg_fs_pol = fpol;
        cfg_ext_en = xen;
        sclk = cpol;
        fs_in = fpol;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "reset oe", tx_oe, 0);
        check("R1", "reset data", tx_d, 0);
        check("R1", "reset ready", in_ready, 1);
        check("R1", "reset underflow", underflow, 0);
        check("R1", "reset fs_out", fs_out, fpol);

        in_valid = 1'b1;
        in_data = words[0];
        @(negedge clk);
        in_valid = 1'b0;
        check("R11", "ready after write", in_ready, 0);

        for (int L = 0; L < NF * per; L++) begin
            bit eo, ed, first;
            int fi;
            string tag;
            bit fs_exp;
            eo = 0; ed = 0; first = 0; fi = 0;
            for (int f = 0; f <= NF; f++) begin
                int i = L - (f * per + d);
                if (i >= 0 && i < len) begin
                    logic [31:0] w = word_for(f);
                    eo = 1; ed = w[len - 1 - i]; first = (i == 0); fi = f;
                end
            end
            if (!eo) tag = "R5";
            else if (first) tag = int_mode ? (d == 0 ? "R3" : "R4") : (d == 0 ? "R3/R8" : "R4/R8");
            else if (fi == SKIP) tag = "R10";
            else tag = "R2";
            tag = {tag, ptag};
            fs_exp = int_mode && (L % per == 0);

            sclk = ~cpol;
            fs_in = (!int_mode && (L % per == 0)) ^ fpol;
            repeat (HALF) @(negedge clk);
            check((first && xen) ? "R6" : tag, "oe high half", tx_oe, eo && !(first && xen));
            check((first && xen) ? "R6" : tag, "data high half", tx_d, ed && !(first && xen));
            check({"R7", ptag}, "fs_out high half", fs_out, fs_exp ^ fpol);

            sclk = cpol;
            if (L >= d && (L - d) % per == 0 && (L - d) / per + 1 < NF && (L - d) / per + 1 != SKIP) begin
                in_valid = 1'b1;
                in_data = words[(L - d) / per + 1];
                @(negedge clk);
                in_valid = 1'b0;
                check("R11", "ready after write", in_ready, 0);
                repeat (HALF - 1) @(negedge clk);
            end else begin
                repeat (HALF) @(negedge clk);
            end
            check(tag, "oe low half", tx_oe, eo);
            check(tag, "data low half", tx_d, ed);
            check({"R7", ptag}, "fs_out low half", fs_out, fs_exp ^ fpol);
            if (L == SKIP * per + d - 1) check("R10", "no underflow yet", underflow, 0);
        end
        check("R10", "underflow sticky", underflow, 1);
    endtask

    initial begin
        int k = 0;
        int lens [3] = '{8, 13, 32};
        for (int li = 0; li < 3; li++) begin
            for (int d = 0; d < 3; d++) begin
                for (int m = 0; m < 2; m++) begin
                    run_config(lens[li], d, lens[li] + ((k % 2 == 1) ? 0 : 3), m == 1,
                               k[1], k[2], (k % 3) == 0, k);
                    k++;
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule